// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block stands in for the command front end of a parallel NOR flash that is driven by the classic unlock-cycle protocol. A host on a simple synchronous memory bus (chip select, write enable, read enable, word address, byte data) talks to a small internal byte array. The array is split into uniform sectors. Plain reads return array bytes. Writes are decoded as commands: a two-write unlock pair, then a command code that opens program, erase, identification or bypass modes. A query mode returns a short parameter table.

Program and erase take a parameterised number of clock cycles. During that time the `busy` pin is high and reads return a polling status byte instead of array data. An unlock-bypass mode lets a host issue program and erase commands repeatedly without repeating the unlock pair.

The bus has no back-pressure. Every request is accepted in the cycle that presents it, so no ready signal exists. A read is served with a fixed latency of one cycle, and `rvalid` marks the returned byte. A write is never stalled. If a write arrives while the block is busy, it is dropped. Read and write may share a cycle: the write is decoded, and the read sees the state from before the write.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset every array byte is 0xFF, the block is in read-array mode with bypass off, `busy` is 0, `rvalid` is 0, and reads return array bytes.
- R2: A command starts with 0xAA written at word `UNLK0` (default 0x55) followed by 0x55 at word `UNLK1` (default 0x2A). A wrong address or wrong data in either cycle aborts to read-array mode, so a later program code has no effect.
- R3: The third write selects the command: 0x80 erase, 0x90 identification, 0xA0 program, 0x20 bypass entry. Outside bypass it must be written at `UNLK0`. Any other code, or a wrong address, aborts to read-array mode.
- R4: The program data write ANDs the byte into the array at its word address, so bits can be cleared but never set.
- R5: Erase takes a second 0xAA/0x55 unlock pair after 0x80. Then 0x30 fills the sector containing the written address with 0xFF, leaves the other sectors untouched, and holds `busy` for `SERASE_CYC` cycles.
- R6: After the erase preamble, 0x10 written at `UNLK0` fills the whole array with 0xFF and holds `busy` for `CERASE_CYC` cycles. 0x10 at any other address aborts with no erase and no busy.
- R7: While an erase is busy, reads return the status byte. Bit 7 reads 0, and bit 6 inverts after every read, so the first two reads give 0x00 then 0x40.
- R8: Every write received while `busy` is high is ignored, including 0xF0 and complete command sequences.
- R9: 0xF0 written in any non-busy state except the program data cycle returns the block to read-array mode and clears bypass. In the program data cycle, 0xF0 is programmed as data.
- R10: In identification mode, words 0 and 1 return `ID0` and `ID1`, and word 2 returns 0x00. Words 0x0E and 0x0F return `ID2` and `ID3` unless that parameter is 0xFF, in which case they read the array. All other words read the array.
- R11: 0x98 at word 0x55 enters query mode from read-array or identification mode. Query reads return table bytes by word index (0x10..0x12 give 0x51, 0x52, 0x59; 0x27 gives log2 of the array size). Words past the table read 0x00. Any write leaves query mode.
- R12: After 0x20 enters bypass, a program (0xA0, data) or erase (0x80, then 0x10/0x30) is accepted with no unlock pair and no address check. After each operation the block waits for the next bypass command. Writing 0x90 then 0x00 leaves bypass.
- R13: A read request presented at a clock edge yields `rvalid` high for exactly the following cycle, with `rdata` valid in that cycle.
- R14: A program holds `busy` for `PROG_CYC` cycles (default 1). Afterwards the block is back in read-array mode, or in the bypass command state when bypass is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, qualifies we and re |
| we | input | 1 | Write request for this cycle |
| re | input | 1 | Read request for this cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | 8 | Write data / command code |
| rdata | output | 8 | Read data, valid when rvalid is high |
| rvalid | output | 1 | High one cycle after an accepted read |
| busy | output | 1 | Program or erase in progress |

## Verification
The command decoder is driven with complete correct sequences and with each kind of broken one: a wrong unlock address, wrong unlock data, a wrong command address and an unknown code. Each broken sequence is followed by a program data write, and the target byte must stay intact, which separates an abort from an accidental acceptance. Programs over bytes that were previously cleared show that the array ANDs rather than overwrites. Sector erase is checked against bytes in the neighbouring sectors, which separates sector-scoped erase from chip erase. Bypass sequences are run with and without unlock cycles, and writes are issued during an erase, which distinguishes persistent mode state from state that a dropped write could have changed.

// File: rtl/nor_pkg.sv
package nor_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_CMD, ST_EUNL0, ST_EUNL1, ST_ECMD,
    ST_PROG, ST_AUTO, ST_CFI, ST_BUSY
  } seq_state_t;

  typedef struct packed {
    logic prog;
    logic wipe_all;
    logic wipe_sect;
  } arr_op_t;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_BYPASS  = 8'h20;
  localparam logic [7:0] CODE_ABORT   = 8'hF0;
  localparam logic [7:0] CODE_QUERY   = 8'h98;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECT    = 8'h30;
  localparam logic [7:0] CODE_BYP_OUT = 8'h00;
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          active,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= (len == '0) ? '0 : len - 1'b1;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5/R6/R14: a running operation stays busy until its count is spent
  assert_busy_hold_R14: assert property (@(posedge clk) disable iff (rst)
    (active && !done) |=> active);
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  nor_pkg::arr_op_t  op,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rbyte
);
  localparam int NWORDS = 1 << ADDR_W;
  localparam int SIDX_W = ADDR_W - SECT_W;

  logic [7:0] mem [NWORDS];
  logic [SIDX_W-1:0] wsect;

  assign wsect = waddr[ADDR_W-1:SECT_W];
  assign rbyte = mem[raddr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NWORDS; i++) begin
      if (rst || op.wipe_all ||
          (op.wipe_sect && (SIDX_W'(i >> SECT_W) == wsect)))
        mem[i] <= 8'hFF;
      else if (op.prog && (ADDR_W'(i) == waddr))
        mem[i] <= mem[i] & wdata;
    end
  end

  // R4: programming never raises a bit that the data byte holds low
  assert_prog_clears_only_R4: assert property (@(posedge clk) disable iff (rst)
    (op.prog && !op.wipe_all && !op.wipe_sect) |=>
      ((mem[$past(waddr)] & ~$past(wdata)) == 8'h00));
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm #(
  parameter int              ADDR_W     = 8,
  parameter int              CW         = 9,
  parameter logic [ADDR_W-1:0] UNLK0    = 'h55,
  parameter logic [ADDR_W-1:0] UNLK1    = 'h2A,
  parameter logic [ADDR_W-1:0] QRY_ADDR = 'h55,
  parameter int              PROG_CYC   = 1,
  parameter int              SERASE_CYC = 40,
  parameter int              CERASE_CYC = 400
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic                tmr_done,
  output nor_pkg::seq_state_t st,
  output logic                byp,
  output logic [7:0]          status,
  output nor_pkg::arr_op_t    op,
  output logic                tmr_start,
  output logic [CW-1:0]       tmr_len
);
  import nor_pkg::*;

  seq_state_t nxt_st;
  logic       nxt_byp;
  logic       stat_load;
  logic [7:0] stat_val;
  logic       at_u0, at_u1, in_cfi;

  assign at_u0  = (addr == UNLK0);
  assign at_u1  = (addr == UNLK1);
  assign in_cfi = (st == ST_CFI);

  always_comb begin
    nxt_st    = st;
    nxt_byp   = byp;
    op        = '0;
    tmr_start = 1'b0;
    tmr_len   = '0;
    stat_load = 1'b0;
    stat_val  = 8'h00;
    if (st == ST_BUSY) begin
      if (tmr_done) nxt_st = byp ? ST_CMD : ST_READ;
    end else if (wr) begin
      nxt_st  = ST_READ;
      nxt_byp = 1'b0;
      if (!(wdata == CODE_ABORT && st != ST_PROG)) begin
        unique case (st)
          ST_READ: begin
            if (addr == QRY_ADDR && wdata == CODE_QUERY) nxt_st = ST_CFI;
            else if (at_u0 && wdata == CODE_KEY_A)       nxt_st = ST_UNL1;
          end
          ST_UNL1:  if (at_u1 && wdata == CODE_KEY_B) nxt_st = ST_CMD;
          ST_EUNL0: if (at_u0 && wdata == CODE_KEY_A) nxt_st = ST_EUNL1;
          ST_EUNL1: if (at_u1 && wdata == CODE_KEY_B) nxt_st = ST_ECMD;
          ST_CMD: begin
            if (byp || at_u0) begin
              nxt_byp = byp;
              case (wdata)
                CODE_BYPASS: begin nxt_byp = 1'b1; nxt_st = ST_CMD; end
                CODE_ERASE:  nxt_st = byp ? ST_ECMD : ST_EUNL0;
                CODE_IDENT:  nxt_st = ST_AUTO;
                CODE_PROG:   nxt_st = ST_PROG;
                default: begin nxt_st = ST_READ; nxt_byp = 1'b0; end
              endcase
            end
          end
          ST_ECMD: begin
            if ((wdata == CODE_CHIP && (byp || at_u0)) || wdata == CODE_SECT) begin
              nxt_st        = ST_BUSY;
              nxt_byp       = byp;
              op.wipe_all   = (wdata == CODE_CHIP);
              op.wipe_sect  = (wdata == CODE_SECT);
              tmr_start     = 1'b1;
              tmr_len       = (wdata == CODE_CHIP) ? CW'(CERASE_CYC) : CW'(SERASE_CYC);
              stat_load     = 1'b1;
            end
          end
          ST_PROG: begin
            nxt_st    = ST_BUSY;
            nxt_byp   = byp;
            op.prog   = 1'b1;
            tmr_start = 1'b1;
            tmr_len   = CW'(PROG_CYC);
            stat_load = 1'b1;
            stat_val  = {~wdata[7], 7'b0};
          end
          ST_AUTO: begin
            if (!(byp && wdata == CODE_BYP_OUT) &&
                addr == QRY_ADDR && wdata == CODE_QUERY)
              nxt_st = ST_CFI;
          end
          default: nxt_st = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_READ;
      byp    <= 1'b0;
      status <= 8'h00;
    end else begin
      st  <= nxt_st;
      byp <= nxt_byp;
      if (stat_load) status <= stat_val;
      else if (st == ST_BUSY) begin
        if (rd)       status[6] <= ~status[6];
        if (tmr_done) status[7] <= ~status[7];
      end
    end
  end

  // R7: each polling read flips the toggle bit
  assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY && rd) |=> (status[6] != $past(status[6])));
  // R11: query mode is reachable only from read-array or identification mode
  assert_query_entry_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(in_cfi) |-> $past(st == ST_READ || st == ST_AUTO));
  // R12: bypass turns on only through its command code
  assert_bypass_entry_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(byp) |-> $past(st == ST_CMD && wr && wdata == CODE_BYPASS));
  // R9: the abort code lands in read-array mode with bypass off
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata == CODE_ABORT && st != ST_PROG && st != ST_BUSY) |=>
      (st == ST_READ && !byp));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int                ADDR_W     = 8,
  parameter int                SECT_W     = 6,
  parameter logic [ADDR_W-1:0] UNLK0      = 'h55,
  parameter logic [ADDR_W-1:0] UNLK1      = 'h2A,
  parameter logic [7:0]        ID0        = 8'h01,
  parameter logic [7:0]        ID1        = 8'hA7,
  parameter logic [7:0]        ID2        = 8'h0C,
  parameter logic [7:0]        ID3        = 8'hFF,
  parameter int                PROG_CYC   = 1,
  parameter int                SERASE_CYC = 40,
  parameter int                CERASE_CYC = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rvalid,
  output logic              busy
);
  import nor_pkg::*;

  localparam int LONG_A  = (SERASE_CYC > PROG_CYC) ? SERASE_CYC : PROG_CYC;
  localparam int LONGEST = (CERASE_CYC > LONG_A) ? CERASE_CYC : LONG_A;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam int NSECT   = 1 << (ADDR_W - SECT_W);
  localparam logic [ADDR_W-1:0] QRY_ADDR = ADDR_W'('h55);

  logic          wr, rd, byp, tmr_start, tmr_done;
  logic [CW-1:0] tmr_len;
  logic [7:0]    status, arr_byte, rd_mux;
  seq_state_t    st;
  arr_op_t       op;

  assign wr = cs & we;
  assign rd = cs & re;

  nor_seq_fsm #(
    .ADDR_W(ADDR_W), .CW(CW), .UNLK0(UNLK0), .UNLK1(UNLK1), .QRY_ADDR(QRY_ADDR),
    .PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
    .tmr_done(tmr_done), .st(st), .byp(byp), .status(status), .op(op),
    .tmr_start(tmr_start), .tmr_len(tmr_len)
  );

  nor_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .len(tmr_len),
    .active(busy), .done(tmr_done)
  );

  nor_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst(rst), .op(op), .waddr(addr), .wdata(wdata),
    .raddr(addr), .rbyte(arr_byte)
  );

  function automatic logic [7:0] qry_byte(input logic [ADDR_W-1:0] a);
    case (int'(a))
      'h10:    return 8'h51;
      'h11:    return 8'h52;
      'h12:    return 8'h59;
      'h13:    return 8'h02;
      'h27:    return 8'(ADDR_W);
      'h2C:    return 8'h01;
      'h2D:    return 8'(NSECT - 1);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [ADDR_W-1:0] a, input logic [7:0] arr);
    case (int'(a))
      'h00:    return ID0;
      'h01:    return ID1;
      'h02:    return 8'h00;
      'h0E:    return (ID2 == 8'hFF) ? arr : ID2;
      'h0F:    return (ID3 == 8'hFF) ? arr : ID3;
      default: return arr;
    endcase
  endfunction

  always_comb begin
    case (st)
      ST_BUSY: rd_mux = status;
      ST_AUTO: rd_mux = id_byte(addr, arr_byte);
      ST_CFI:  rd_mux = qry_byte(addr);
      default: rd_mux = arr_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= 8'h00;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end

  // R13: one-cycle read latency, one valid cycle per request
  assert_read_latency_R13: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  assert_no_spurious_valid_R13: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);
  // R8: nothing touches the array or restarts the timer while busy
  assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(op.prog || op.wipe_all || op.wipe_sect || tmr_start));
endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
  localparam logic [7:0] U0 = 8'h55, U1 = 8'h2A;
  localparam logic [7:0] I0 = 8'h01, I1 = 8'hA7, I2 = 8'h0C, I3 = 8'hFF;
  localparam int PC = 1, SC = 40, CC = 400;

  logic clk = 1'b0;
  logic rst, cs, we, re, rvalid, busy;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] model [256];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nor_cmd_seq #(
    .ADDR_W(8), .SECT_W(6), .UNLK0(U0), .UNLK1(U1), .ID0(I0), .ID1(I1),
    .ID2(I2), .ID3(I3), .PROG_CYC(PC), .SERASE_CYC(SC), .CERASE_CYC(CC)
  ) uut (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy)
  );

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; re = 1; addr = a;
    @(negedge clk); d = rdata; cs = 0; re = 0;
  endtask

  task automatic unlock();
    bwr(U0, 8'hAA); bwr(U1, 8'h55);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic chk_mem(input string req, input logic [7:0] a);
    logic [7:0] d;
    brd(a, d);
    check(req, d, model[a]);
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d, output int n);
    unlock(); bwr(U0, 8'hA0); bwr(a, d);
    model[a] = model[a] & d;
    wait_idle(n);
  endtask

  task automatic erase_pre();
    unlock(); bwr(U0, 8'h80); unlock();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 busy", busy, 0);
    check("R1 rvalid", rvalid, 0);
    brd(8'h00, d); check("R1 byte 00", d, 8'hFF);
    brd(8'h7F, d); check("R1 byte 7F", d, 8'hFF);
    brd(8'hFF, d); check("R1 byte FF", d, 8'hFF);
  endtask

  task automatic t_latency();
    @(negedge clk); cs = 1; re = 1; addr = 8'h10;
    @(negedge clk); check("R13 rvalid high", rvalid, 1); cs = 0; re = 0;
    @(negedge clk); check("R13 rvalid low", rvalid, 0);
  endtask

  task automatic t_program();
    int n;
    prog(8'h05, 8'h0F, n); check("R14 program busy cycles", n, PC);
    chk_mem("R4 first program", 8'h05);
    prog(8'h05, 8'hF3, n); chk_mem("R4 AND program", 8'h05);
    check("R4 expected 03", model[8'h05], 8'h03);
    prog(8'h06, 8'hF0, n); chk_mem("R9 F0 as program data", 8'h06);
  endtask

  task automatic t_bad_unlock();
    bwr(U0, 8'hAA); bwr(8'h2B, 8'h55); bwr(U0, 8'hA0); bwr(8'h30, 8'h00);
    check("R2 no busy after bad address", busy, 0);
    chk_mem("R2 bad unlock address", 8'h30);
    bwr(U0, 8'hAA); bwr(U1, 8'h54); bwr(U0, 8'hA0); bwr(8'h31, 8'h00);
    chk_mem("R2 bad unlock data", 8'h31);
  endtask

  task automatic t_bad_cmd();
    unlock(); bwr(8'h10, 8'hA0); bwr(8'h32, 8'h00);
    chk_mem("R3 command at wrong address", 8'h32);
    unlock(); bwr(U0, 8'h42); bwr(8'h33, 8'h00);
    chk_mem("R3 unknown command code", 8'h33);
  endtask

  task automatic t_sector_erase();
    int n;
    logic [7:0] s1, s2;
    prog(8'h45, 8'h12, n); prog(8'h7F, 8'h00, n);
    erase_pre(); bwr(8'h47, 8'h30);
    for (int i = 8'h40; i < 8'h80; i++) model[i] = 8'hFF;
    wait_idle(n); check("R5 sector erase busy cycles", n, SC);
    chk_mem("R5 erased sector byte 45", 8'h45);
    chk_mem("R5 erased sector byte 7F", 8'h7F);
    chk_mem("R5 other sector untouched", 8'h05);
    prog(8'h48, 8'h00, n);
    erase_pre(); bwr(8'h40, 8'h30);
    model[8'h48] = 8'hFF;
    brd(8'h00, s1); brd(8'h00, s2);
    check("R7 first poll", s1, 8'h00);
    check("R7 second poll", s2, 8'h40);
    bwr(8'h00, 8'hF0);
    check("R8 abort ignored while busy", busy, 1);
    unlock(); bwr(U0, 8'hA0); bwr(8'h05, 8'h00);
    wait_idle(n);
    chk_mem("R8 program during erase dropped", 8'h05);
    chk_mem("R5 second sector erase", 8'h48);
  endtask

  task automatic t_chip_erase();
    int n;
    erase_pre(); bwr(8'h00, 8'h10);
    check("R6 chip erase wrong address no busy", busy, 0);
    chk_mem("R6 no erase on wrong address", 8'h05);
    erase_pre(); bwr(U0, 8'h10);
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    wait_idle(n); check("R6 chip erase busy cycles", n, CC);
    for (int i = 0; i < 256; i++) chk_mem("R6 chip erased byte", 8'(i));
  endtask

  task automatic t_ident();
    int n;
    logic [7:0] d;
    prog(8'h0F, 8'h5A, n); prog(8'h20, 8'h77, n);
    unlock(); bwr(U0, 8'h90);
    brd(8'h00, d); check("R10 ID0", d, I0);
    brd(8'h01, d); check("R10 ID1", d, I1);
    brd(8'h02, d); check("R10 protect word", d, 8'h00);
    brd(8'h0E, d); check("R10 ID2", d, I2);
    brd(8'h0F, d); check("R10 ID3 absent reads array", d, 8'h5A);
    brd(8'h20, d); check("R10 other word reads array", d, 8'h77);
    bwr(8'h55, 8'h98);
    brd(8'h10, d); check("R11 query from identification", d, 8'h51);
    bwr(8'h00, 8'h00);
    chk_mem("R11 write leaves query mode", 8'h10);
    unlock(); bwr(U0, 8'h90); bwr(8'h00, 8'hF0);
    chk_mem("R9 abort from identification", 8'h00);
  endtask

  task automatic t_query();
    logic [7:0] d;
    bwr(8'h55, 8'h98);
    brd(8'h11, d); check("R11 query R", d, 8'h52);
    brd(8'h12, d); check("R11 query Y", d, 8'h59);
    brd(8'h27, d); check("R11 size code", d, 8'h08);
    brd(8'hA0, d); check("R11 past table", d, 8'h00);
    bwr(8'h10, 8'hF0);
    chk_mem("R11 abort leaves query", 8'h11);
  endtask

  task automatic t_bypass();
    int n;
    unlock(); bwr(U0, 8'h20);
    bwr(8'h80, 8'hA0); bwr(8'h81, 8'h3C); model[8'h81] = 8'h3C;
    wait_idle(n); check("R14 bypass program busy cycles", n, PC);
    chk_mem("R12 bypass program", 8'h81);
    bwr(8'h00, 8'hA0); bwr(8'h82, 8'h0F); model[8'h82] = 8'h0F;
    wait_idle(n); chk_mem("R14 returns to bypass command state", 8'h82);
    bwr(8'h10, 8'h80); bwr(8'h85, 8'h30);
    model[8'h81] = 8'hFF; model[8'h82] = 8'hFF;
    bwr(8'h00, 8'hF0);
    check("R8 abort ignored during bypass erase", busy, 1);
    wait_idle(n); check("R12 bypass sector erase cycles", n, SC - 2);
    chk_mem("R12 bypass erase", 8'h81);
    bwr(8'h00, 8'hA0); bwr(8'h90, 8'h55); model[8'h90] = 8'h55;
    wait_idle(n); chk_mem("R8 bypass kept across erase", 8'h90);
    bwr(8'h00, 8'h90); bwr(8'h00, 8'h00);
    bwr(U0, 8'hA0); bwr(8'h91, 8'h00);
    chk_mem("R12 bypass exit", 8'h91);
    unlock(); bwr(U0, 8'h20); bwr(8'h00, 8'hF0);
    bwr(U0, 8'hA0); bwr(8'h92, 8'h00);
    chk_mem("R9 abort clears bypass", 8'h92);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    rst = 1; cs = 0; we = 0; re = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_program();
    t_bad_unlock();
    t_bad_cmd();
    t_sector_erase();
    t_chip_erase();
    t_ident();
    t_query();
    t_bypass();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule